// File: doc/BRIEF.md
# Outbound Request Queue with Halt-on-Error Flush

This block sits between a local requester and a serial link and holds outbound requests in arrival order. Each request is either a posted write or a non-posted read and carries a data word. Software owns two control bits: an intake enable and a halt-on-error enable. The link side checks parity on queued writes. When it finds an address or data parity error, it reports the queue slot of the failing entry on an error strobe.

An error on a live write always raises a sticky parity-error interrupt. If halt-on-error is also set, the block does three more things. It clears the intake enable, so no request of any kind is accepted. It discards every write that is strictly younger than the failing one. It raises a sticky halt interrupt. The failing write, every older entry and every queued read still drain to the link in their original order. Intake resumes only when software writes the enable bit again. Both interrupts stay set until software pulses the clear input.

Both data interfaces use valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the enable bit is 0 or while the queue holds `DEPTH` entries. On the link side, once `out_valid` is high its payload (`out_is_write`, `out_data`, `out_slot`) holds still until `out_ready` takes it. Discarded entries are skipped silently and never shown on the outputs. Each skipped entry takes one idle cycle.

Top module: `ob_halt_queue`

## Requirements
- R1: After reset, the intake enable, the halt-on-error enable, both interrupts, `req_ready` and `out_valid` are all 0.
- R2: A `cfg_wr` pulse loads `cfg_enable` into the intake enable (seen on `ob_enable`) and `cfg_halt_en` into the halt-on-error enable. `req_ready` is 1 exactly when the intake enable is 1 and fewer than `DEPTH` entries are held.
- R3: Entries leave in arrival order with their kind (`out_is_write`: 1 = write, 0 = read), data and slot index unchanged. While `out_valid` is 1 and `out_ready` is 0, the outputs hold stable.
- R4: With `DEPTH` (8) entries held, `req_ready` is 0. Slot indices are assigned in rotation 0 to `DEPTH`-1.
- R5: With halt-on-error disabled, an error on a live write sets `irq_perr` in the next cycle. It leaves `ob_enable`, `irq_halt` and the queue contents unchanged.
- R6: With halt-on-error enabled, an error on a live write gives the following in the next cycle: `ob_enable` is 0, `req_ready` is 0, and `irq_halt` and `irq_perr` are both 1.
- R7: On a halting error, the queued writes strictly younger than the failing slot are discarded. The failing write, all older entries and all reads are delivered in order.
- R8: An error strobe that names an empty slot, a read, or an already discarded write is ignored. The interrupts, `ob_enable` and the queue stay unchanged.
- R9: Both interrupts stay set until an `irq_clr` pulse clears them. After a halt, `ob_enable` stays 0 until software writes it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the two control bits |
| cfg_enable | input | 1 | Intake enable value to load |
| cfg_halt_en | input | 1 | Halt-on-error enable value to load |
| irq_clr | input | 1 | Clear both interrupts |
| ob_enable | output | 1 | Current intake enable |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_is_write | input | 1 | 1 = posted write, 0 = read |
| req_data | input | DATA_W | Request payload |
| out_valid | output | 1 | Head entry offered to the link |
| out_ready | input | 1 | Link takes the head entry |
| out_is_write | output | 1 | Kind of head entry |
| out_data | output | DATA_W | Payload of head entry |
| out_slot | output | IDX_W | Queue slot of head entry |
| perr_valid | input | 1 | Parity error strobe |
| perr_slot | input | IDX_W | Slot of the failing entry |
| irq_halt | output | 1 | Sticky halt interrupt |
| irq_perr | output | 1 | Sticky parity-error interrupt |

## Verification
The assertions assume several things about the inputs. Error strobes name a slot taken from `out_slot` or from the rotation of slot numbers. `out_ready` is raised only toward an entry that is being offered. `DEPTH` is a power of two, so slot ages wrap cleanly. The bench predicts slot numbers by counting its own accepted pushes modulo 8. It raises `out_ready` only after it sees `out_valid`. It pulses the error strobe only while the link side is idle, so each check sees a single cause.

// File: rtl/ob_halt_pkg.sv
package ob_halt_pkg;
  typedef enum logic {
    REQ_READ  = 1'b0,
    REQ_WRITE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/ob_req_fifo.sv
module ob_req_fifo
  import ob_halt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  req_kind_e         push_kind,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_kill,
  input  logic              pop,
  input  logic              kill_en,
  input  logic [DEPTH-1:0]  kill_mask,
  output logic [IDX_W-1:0]  head_idx,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output req_kind_e         head_kind,
  output logic [DATA_W-1:0] head_data,
  output logic              head_killed,
  output logic [DEPTH-1:0]  slot_is_wr,
  output logic [DEPTH-1:0]  slot_killed
);
  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  req_kind_e         kind_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  killed_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      killed_q <= '0;
      for (int i = 0; i < DEPTH; i++) kind_q[i] <= REQ_READ;
    end else begin
      if (kill_en) killed_q <= killed_q | kill_mask;
      if (push) begin
        kind_q[tail_q]   <= push_kind;
        killed_q[tail_q] <= push_kill;
        tail_q           <= step(tail_q);
      end
      if (pop) head_q <= step(head_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) data_q[tail_q] <= push_data;
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign slot_is_wr[s] = (kind_q[s] == REQ_WRITE);
    end
  endgenerate

  assign slot_killed = killed_q;
  assign head_idx    = head_q;
  assign count       = cnt_q;
  assign full        = (cnt_q == CNT_W'(DEPTH));
  assign empty       = (cnt_q == '0);
  assign head_kind   = kind_q[head_q];
  assign head_data   = data_q[head_q];
  assign head_killed = killed_q[head_q];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/ob_flush_mask.sv
module ob_flush_mask #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             err_valid,
  input  logic [IDX_W-1:0] err_idx,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [CNT_W-1:0] count,
  input  logic [DEPTH-1:0] slot_is_wr,
  input  logic [DEPTH-1:0] slot_killed,
  output logic             hit,
  output logic [DEPTH-1:0] kill_mask
);
  logic [DEPTH-1:0] live;
  logic [IDX_W-1:0] err_age;

  assign err_age = err_idx - head_idx;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_age
      logic [IDX_W-1:0] age;
      assign age          = IDX_W'(s) - head_idx;
      assign live[s]      = (CNT_W'(age) < count) && !slot_killed[s];
      assign kill_mask[s] = live[s] && slot_is_wr[s] && (age > err_age);
    end
  endgenerate

  assign hit = err_valid && live[err_idx] && slot_is_wr[err_idx];
endmodule

// File: rtl/ob_ctl_regs.sv
module ob_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_enable,
  input  logic cfg_halt_en,
  input  logic irq_clr,
  input  logic perr_hit,
  output logic ob_enable,
  output logic halt_en,
  output logic halt_evt,
  output logic irq_halt,
  output logic irq_perr
);
  assign halt_evt = perr_hit && halt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_enable <= 1'b0;
      halt_en   <= 1'b0;
      irq_halt  <= 1'b0;
      irq_perr  <= 1'b0;
    end else begin
      if (halt_evt)    ob_enable <= 1'b0;
      else if (cfg_wr) ob_enable <= cfg_enable;
      if (cfg_wr) halt_en <= cfg_halt_en;
      if (halt_evt)     irq_halt <= 1'b1;
      else if (irq_clr) irq_halt <= 1'b0;
      if (perr_hit)     irq_perr <= 1'b1;
      else if (irq_clr) irq_perr <= 1'b0;
    end
  end

  assert_halt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> (!ob_enable && irq_halt && irq_perr));
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_halt && !irq_clr) |=> irq_halt);
  assert_enable_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_hit && !halt_en && !cfg_wr) |=> (ob_enable == $past(ob_enable)));
endmodule

// File: rtl/ob_halt_queue.sv
module ob_halt_queue
  import ob_halt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_enable,
  input  logic              cfg_halt_en,
  input  logic              irq_clr,
  output logic              ob_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [DATA_W-1:0] req_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_write,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_slot,
  input  logic              perr_valid,
  input  logic [IDX_W-1:0]  perr_slot,
  output logic              irq_halt,
  output logic              irq_perr
);
  logic             push, pop, full, empty, head_killed;
  logic             perr_hit, halt_en, halt_evt;
  logic [IDX_W-1:0] head_idx;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] slot_is_wr, slot_killed, kill_mask;
  req_kind_e        head_kind;

  ob_ctl_regs u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_enable (cfg_enable),
    .cfg_halt_en(cfg_halt_en),
    .irq_clr    (irq_clr),
    .perr_hit   (perr_hit),
    .ob_enable  (ob_enable),
    .halt_en    (halt_en),
    .halt_evt   (halt_evt),
    .irq_halt   (irq_halt),
    .irq_perr   (irq_perr)
  );

  ob_flush_mask #(.DEPTH(DEPTH)) u_mask (
    .err_valid  (perr_valid),
    .err_idx    (perr_slot),
    .head_idx   (head_idx),
    .count      (count),
    .slot_is_wr (slot_is_wr),
    .slot_killed(slot_killed),
    .hit        (perr_hit),
    .kill_mask  (kill_mask)
  );

  ob_req_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_kind  (req_is_write ? REQ_WRITE : REQ_READ),
    .push_data  (req_data),
    .push_kill  (halt_evt && req_is_write),
    .pop        (pop),
    .kill_en    (halt_evt),
    .kill_mask  (kill_mask),
    .head_idx   (head_idx),
    .count      (count),
    .full       (full),
    .empty      (empty),
    .head_kind  (head_kind),
    .head_data  (out_data),
    .head_killed(head_killed),
    .slot_is_wr (slot_is_wr),
    .slot_killed(slot_killed)
  );

  assign req_ready    = ob_enable && !full;
  assign push         = req_valid && req_ready;
  assign out_valid    = !empty && !head_killed;
  assign pop          = (out_valid && out_ready) || (!empty && head_killed);
  assign out_is_write = (head_kind == REQ_WRITE);
  assign out_slot     = head_idx;

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_slot)));
endmodule

// File: tb/test_ob_halt_queue.sv
module test_ob_halt_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_enable = 0, cfg_halt_en = 0, irq_clr = 0;
  logic        ob_enable, req_ready, out_valid, out_is_write, irq_halt, irq_perr;
  logic        req_valid = 0, req_is_write = 0, out_ready = 0, perr_valid = 0;
  logic [31:0] req_data = '0, out_data;
  logic [2:0]  out_slot, perr_slot = '0;
  int checks = 0, fails = 0, nxt = 0;

  always #2 clk = ~clk;

  ob_halt_queue i_ob_halt_queue (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_halt_en(cfg_halt_en), .irq_clr(irq_clr), .ob_enable(ob_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
    .req_data(req_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_write(out_is_write), .out_data(out_data), .out_slot(out_slot),
    .perr_valid(perr_valid), .perr_slot(perr_slot), .irq_halt(irq_halt),
    .irq_perr(irq_perr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic en, input logic halt);
    cfg_wr = 1; cfg_enable = en; cfg_halt_en = halt;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic push(input logic w, input logic [31:0] d, output int slot);
    chk("R2 ready before push", req_ready, 1);
    req_valid = 1; req_is_write = w; req_data = d;
    slot = nxt % 8;
    nxt++;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pop_expect(input string tag, input logic w, input logic [31:0] d, input int slot);
    for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " kind"}, out_is_write, w);
    chk({tag, " data"}, out_data, d);
    chk({tag, " slot"}, out_slot, slot);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic expect_empty(input string tag);
    repeat (3) @(negedge clk);
    chk(tag, out_valid, 0);
  endtask

  task automatic flag_err(input int slot);
    perr_valid = 1; perr_slot = 3'(slot);
    @(negedge clk);
    perr_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 ob_enable", ob_enable, 0);
    chk("R1 req_ready", req_ready, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 irq_halt", irq_halt, 0);
    chk("R1 irq_perr", irq_perr, 0);
  endtask

  task automatic t_basic();
    int s0, s1, s2;
    logic [31:0] held;
    sw_write(1, 0);
    chk("R2 enable readback", ob_enable, 1);
    chk("R2 ready after enable", req_ready, 1);
    push(1, 32'hA0, s0);
    push(0, 32'hB1, s1);
    push(1, 32'hC2, s2);
    held = out_data;
    repeat (3) @(negedge clk);
    chk("R3 hold valid", out_valid, 1);
    chk("R3 hold data", out_data, held);
    pop_expect("R3 order 0", 1, 32'hA0, s0);
    pop_expect("R3 order 1", 0, 32'hB1, s1);
    pop_expect("R3 order 2", 1, 32'hC2, s2);
    expect_empty("R3 drained");
    sw_write(0, 0);
    chk("R2 ready after disable", req_ready, 0);
    chk("R2 enable cleared", ob_enable, 0);
  endtask

  task automatic t_full();
    int sl [8];
    sw_write(1, 0);
    for (int i = 0; i < 8; i++) push(i[0], 32'h100 + i, sl[i]);
    chk("R4 ready low when full", req_ready, 0);
    for (int i = 0; i < 8; i++) pop_expect("R4 drain", i[0], 32'h100 + i, sl[i]);
    chk("R4 ready back", req_ready, 1);
  endtask

  task automatic t_no_halt();
    int a, b, c;
    sw_write(1, 0);
    push(1, 32'h11, a);
    push(1, 32'h22, b);
    push(1, 32'h33, c);
    flag_err(a);
    chk("R5 irq_perr", irq_perr, 1);
    chk("R5 irq_halt", irq_halt, 0);
    chk("R5 enable kept", ob_enable, 1);
    pop_expect("R5 keep a", 1, 32'h11, a);
    pop_expect("R5 keep b", 1, 32'h22, b);
    pop_expect("R5 keep c", 1, 32'h33, c);
    pulse_clr();
    chk("R9 perr cleared", irq_perr, 0);
  endtask

  task automatic t_halt();
    int a, b, c, d, e, f;
    sw_write(1, 1);
    push(1, 32'h201, a);
    push(0, 32'h202, b);
    push(1, 32'h203, c);
    push(1, 32'h204, d);
    push(0, 32'h205, e);
    push(1, 32'h206, f);
    flag_err(c);
    chk("R6 enable cleared", ob_enable, 0);
    chk("R6 ready low", req_ready, 0);
    chk("R6 irq_halt", irq_halt, 1);
    chk("R6 irq_perr", irq_perr, 1);
    repeat (4) @(negedge clk);
    chk("R9 halt sticky", irq_halt, 1);
    pop_expect("R7 older write", 1, 32'h201, a);
    pop_expect("R7 older read", 0, 32'h202, b);
    pop_expect("R7 failing write", 1, 32'h203, c);
    pop_expect("R7 younger read", 0, 32'h205, e);
    expect_empty("R7 younger writes gone");
    chk("R6 still no intake", req_ready, 0);
    pulse_clr();
    chk("R9 halt cleared", irq_halt, 0);
    chk("R9 perr cleared", irq_perr, 0);
    chk("R9 enable stays off", ob_enable, 0);
    sw_write(1, 1);
    chk("R9 intake resumes", req_ready, 1);
  endtask

  task automatic t_ignored();
    int a, b;
    sw_write(1, 1);
    push(0, 32'h301, a);
    push(1, 32'h302, b);
    flag_err(a);
    chk("R8 read error no irq", irq_perr, 0);
    chk("R8 read error enable", ob_enable, 1);
    flag_err((b + 3) % 8);
    chk("R8 empty slot no irq", irq_perr, 0);
    chk("R8 empty slot no halt", irq_halt, 0);
    pop_expect("R8 queue intact 0", 0, 32'h301, a);
    pop_expect("R8 queue intact 1", 1, 32'h302, b);
    expect_empty("R8 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_full();
    t_no_halt();
    t_halt();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule